// File: doc/BRIEF.md
# Resistorless Two-Wire Bus Master

This block is the master side of an I2C-compatible two-wire link that has no pull-up resistors on its wires. The master never leaves a wire floating to rise on its own. It raises SDA with an active driver in one fixed time slot, and it lets any device lower SDA only in a later slot. Weak keepers hold each wire's level between those slots. Every SCL-low interval is cut into five slots of equal length. A slot ends on each pulse of `subTick`, a strobe that comes from a local oscillator. Slots one, three and five carry no drive. They are guard time that absorbs a mismatch of about a quarter in slot length between devices that each run their own oscillator.

A host hands the block one command at a time: start, write a byte, read a byte (answering ack or nack), or stop. The block produces drive-high, drive-low and keeper-enable controls for each wire. It shows the SDA level it captured at each rising SCL edge. At the end of each byte it reports the eight data bits and the acknowledge bit, and it raises a sticky error flag when a written byte is not acknowledged. Arbitration between masters and clock stretching by slaves are not handled.

Top module: `slotBusMaster`

## Requirements
- R1: `cmdReady` is high only while no command is in progress. A command is taken on a clock where `cmdValid` and `cmdReady` are both high and `cmdOp` is one of 1 (start), 2 (write byte), 3 (read byte) or 4 (stop). Codes 0, 5, 6 and 7 are ignored: `cmdReady` stays high and no wire is driven.
- R2: The first slot begins at the first `subTick` after a command is taken. Each SCL-low phase lasts exactly five slots, and `sclDriveLo` is high for all five.
- R3: In every SCL-low phase, `sdaDriveHi` is high throughout the second slot (slot index 1) and in no other slot of that phase.
- R4: Within an SCL-low phase, `sdaDriveLo` may be high only in the fourth slot (index 3). It is high there exactly when the master sends a 0. Slots 0, 2 and 4 drive neither wire level on SDA.
- R5: After each bit's low phase, SCL stays high for HIGH_TICKS slots. `sclDriveHi` is high in the first of these slots only, and the keeper holds SCL for the rest.
- R6: On each wire, drive-high and drive-low are never both high. The keeper enable of a wire is high exactly when neither of its drives is high.
- R7: `sdaSample` takes the value of `sdaIn` on the `subTick` that ends the fifth low slot, which is the rising edge of SCL.
- R8: A write sends `cmdData` most significant bit first over eight bit cells. A ninth cell follows in which the master only precharges SDA. When the command finishes, `rspValid` is high for one clock and `cmdReady` rises on the same edge. At that point `rspData` holds the eight sampled data bits and `rspNack` holds the sampled ninth bit, where 1 means not acknowledged.
- R9: A read precharges SDA in every cell and never pulls it low during the eight data cells. In the ninth cell the master pulls SDA low if `cmdNack` is 0. `rspData` returns the sampled byte, and `rspNack` returns the sampled ninth bit.
- R10: `protoErr` goes high when a write completes with its ninth bit sampled as 1. It stays high until a start command is taken, which clears it on that same edge.
- R11: A start from the idle state takes four SCL-high slots: SCL driven high, a guard slot, SDA driven low, a guard slot. If a start follows an earlier start with no stop in between, it is preceded by one SCL-low phase in which SDA is precharged and never pulled low.
- R12: A stop takes one SCL-low phase with SDA pulled low in slot index 3, then four SCL-high slots: SCL driven high, a guard slot, SDA driven high, a guard slot.
- R13: While reset is held, no drive is high, both keepers are enabled, `cmdReady` is 1, `rspValid` and `protoErr` are 0, and `sdaSample` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| subTick | input | 1 | One-clock strobe that ends the current slot |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 3 | Command code: 1 start, 2 write, 3 read, 4 stop |
| cmdData | input | 8 | Byte to write |
| cmdNack | input | 1 | For a read: 1 answers nack, 0 answers ack |
| cmdReady | output | 1 | Block is idle and will take a command |
| sclDriveHi | output | 1 | Active high driver on SCL |
| sclDriveLo | output | 1 | Active low driver on SCL |
| sclKeep | output | 1 | Weak keeper enable on SCL |
| sdaDriveHi | output | 1 | Active high driver on SDA |
| sdaDriveLo | output | 1 | Active low driver on SDA |
| sdaKeep | output | 1 | Weak keeper enable on SDA |
| sdaIn | input | 1 | Level sensed on the SDA wire |
| sdaSample | output | 1 | SDA level captured at the last SCL rise |
| rspValid | output | 1 | One-clock pulse when a byte command finishes |
| rspData | output | 8 | Sampled data byte |
| rspNack | output | 1 | Sampled acknowledge bit (1 = not acknowledged) |
| protoErr | output | 1 | Sticky flag: a written byte was not acknowledged |

## Verification
The bench builds the block with HIGH_TICKS set to 3 instead of its default of 5, and it pulses `subTick` every third clock. Each slot therefore spans several clocks. A drive that appears one clock early or late, or a high phase that is one slot too long or too short, then shows up as a mismatch in the clock-by-clock comparison. A slave model pulls the line low in slot index 3 for acks and for zero read bits. This lets the bench exercise repeated start, a write that is not acknowledged together with the flag that records it, and a read answered with nack, all against the same timeline.

// File: rtl/slotbus_pkg.sv
package slotbus_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_STOP  = 3'd4
  } busOp_e;

  // Which condition makes the master pull SDA low in slot index 3
  typedef enum logic [1:0] {
    LO_NONE,
    LO_DATA,
    LO_ACK,
    LO_FORCE
  } loSrc_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   loadCmd;
    logic   clrErr;
    logic   sample;
    logic   byteOp;
    logic   ackBit;
    logic   finish;
    logic   checkAck;
    logic   sclHi;
    logic   sclLo;
    logic   sdaHi;
    logic   sdaLoSlot;
    loSrc_e loSrc;
    logic   sdaLoEdge;
  } dpStrobe_t;

endpackage

// File: rtl/slotbus_ctrl.sv
module slotbus_ctrl
  import slotbus_pkg::*;
#(
  parameter int HIGH_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output logic       cmdReady,
  output dpStrobe_t  strb
);

  localparam int LOW_SLOTS  = 5;
  localparam int EDGE_SLOTS = 4;
  localparam int BYTE_CELLS = 9;
  localparam int HCW        = (HIGH_TICKS > 1) ? $clog2(HIGH_TICKS) : 1;
  localparam logic [HCW-1:0] HIGH_LAST = HCW'(HIGH_TICKS - 1);
  localparam logic [2:0] LOW_LAST  = 3'(LOW_SLOTS - 1);
  localparam logic [2:0] EDGE_LAST = 3'(EDGE_SLOTS - 1);
  localparam logic [3:0] ACK_IDX   = 4'(BYTE_CELLS - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PEND, ST_LOW, ST_HIGH, ST_EDGE} ctlState_e;

  ctlState_e      state;
  busOp_e         op;
  logic [2:0]     slotCnt;
  logic [HCW-1:0] highCnt;
  logic [3:0]     bitIdx;
  logic           busActive;
  logic           opValid;
  logic           accept;

  assign opValid  = (cmdOp >= 3'd1) && (cmdOp <= 3'd4);
  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdReady && cmdValid && opValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      op        <= OP_NONE;
      slotCnt   <= '0;
      highCnt   <= '0;
      bitIdx    <= '0;
      busActive <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op    <= busOp_e'(cmdOp);
          state <= ST_PEND;
        end
        ST_PEND: if (subTick) begin
          slotCnt <= '0;
          highCnt <= '0;
          bitIdx  <= '0;
          if (op == OP_START && !busActive) state <= ST_EDGE;
          else                              state <= ST_LOW;
        end
        ST_LOW: if (subTick) begin
          if (slotCnt == LOW_LAST) begin
            slotCnt <= '0;
            highCnt <= '0;
            state   <= (op == OP_START || op == OP_STOP) ? ST_EDGE : ST_HIGH;
          end else begin
            slotCnt <= slotCnt + 3'd1;
          end
        end
        ST_HIGH: if (subTick) begin
          if (highCnt == HIGH_LAST) begin
            if (bitIdx == ACK_IDX) begin
              state <= ST_IDLE;
            end else begin
              bitIdx <= bitIdx + 4'd1;
              state  <= ST_LOW;
            end
          end else begin
            highCnt <= highCnt + HCW'(1);
          end
        end
        ST_EDGE: if (subTick) begin
          if (slotCnt == EDGE_LAST) begin
            state     <= ST_IDLE;
            busActive <= (op == OP_START);
          end else begin
            slotCnt <= slotCnt + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic lowPh;
  logic edgePh;
  assign lowPh  = (state == ST_LOW);
  assign edgePh = (state == ST_EDGE);

  always_comb begin
    strb           = '0;
    strb.loadCmd   = accept;
    strb.clrErr    = accept && (cmdOp == 3'd1);
    strb.sample    = lowPh && subTick && (slotCnt == LOW_LAST);
    strb.byteOp    = (op == OP_WRITE) || (op == OP_READ);
    strb.ackBit    = (bitIdx == ACK_IDX);
    strb.finish    = (state == ST_HIGH) && subTick && (highCnt == HIGH_LAST) && (bitIdx == ACK_IDX);
    strb.checkAck  = (op == OP_WRITE);
    strb.sclHi     = ((state == ST_HIGH) && (highCnt == '0)) || (edgePh && slotCnt == 3'd0);
    strb.sclLo     = lowPh;
    strb.sdaHi     = (lowPh && slotCnt == 3'd1) || (edgePh && slotCnt == 3'd2 && op == OP_STOP);
    strb.sdaLoSlot = lowPh && (slotCnt == 3'd3);
    strb.sdaLoEdge = edgePh && (slotCnt == 3'd2) && (op == OP_START);
    case (op)
      OP_STOP:  strb.loSrc = LO_FORCE;
      OP_WRITE: strb.loSrc = (bitIdx == ACK_IDX) ? LO_NONE : LO_DATA;
      OP_READ:  strb.loSrc = (bitIdx == ACK_IDX) ? LO_ACK : LO_NONE;
      default:  strb.loSrc = LO_NONE;
    endcase
  end

  // R2: a low phase never runs past its fifth slot
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW) |-> (slotCnt <= LOW_LAST));

  // R1: taking a command drops ready on the next clock
  p_take_drops_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && opValid) |=> !cmdReady);

  // R1: an unknown code leaves the block idle
  p_bad_code_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && cmdValid && !opValid) |=> cmdReady);

  // R5: the high phase counter stays inside its window
  p_high_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH) |-> (highCnt <= HIGH_LAST));

endmodule

// File: rtl/slotbus_dp.sv
module slotbus_dp
  import slotbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic [7:0] cmdData,
  input  logic       cmdNack,
  input  logic       sdaIn,
  output logic       sclDriveHi,
  output logic       sclDriveLo,
  output logic       sclKeep,
  output logic       sdaDriveHi,
  output logic       sdaDriveLo,
  output logic       sdaKeep,
  output logic       sdaSample,
  output logic       rspValid,
  output logic [7:0] rspData,
  output logic       rspNack,
  output logic       protoErr
);

  logic [7:0] shReg;
  logic       ackOut;
  logic       ackSmp;
  logic       masterLo;

  always_comb begin
    case (strb.loSrc)
      LO_DATA:  masterLo = !shReg[7];
      LO_ACK:   masterLo = !ackOut;
      LO_FORCE: masterLo = 1'b1;
      default:  masterLo = 1'b0;
    endcase
  end

  assign sclDriveHi = strb.sclHi;
  assign sclDriveLo = strb.sclLo;
  assign sdaDriveHi = strb.sdaHi;
  assign sdaDriveLo = (strb.sdaLoSlot && masterLo) || strb.sdaLoEdge;
  assign sclKeep    = !sclDriveHi && !sclDriveLo;
  assign sdaKeep    = !sdaDriveHi && !sdaDriveLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      ackOut    <= 1'b0;
      ackSmp    <= 1'b0;
      sdaSample <= 1'b1;
      rspValid  <= 1'b0;
      rspData   <= '0;
      rspNack   <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      if (strb.loadCmd) begin
        shReg  <= cmdData;
        ackOut <= cmdNack;
      end
      if (strb.clrErr) protoErr <= 1'b0;
      if (strb.sample) begin
        sdaSample <= sdaIn;
        if (strb.byteOp) begin
          if (strb.ackBit) ackSmp <= sdaIn;
          else             shReg  <= {shReg[6:0], sdaIn};
        end
      end
      if (strb.finish) begin
        rspValid <= 1'b1;
        rspData  <= shReg;
        rspNack  <= ackSmp;
        if (strb.checkAck && ackSmp) protoErr <= 1'b1;
      end
    end
  end

  // R6: opposing drivers on one wire are never on together
  p_sda_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(sdaDriveHi && sdaDriveLo));
  p_scl_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(sclDriveHi && sclDriveLo));

  // R4: a pull-down never directly follows the precharge slot
  p_guard_after_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveHi |=> !sdaDriveLo);

  // R4: SDA is never pulled low while SCL is being driven high
  p_lo_not_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLo |-> !sclDriveHi);

  // R8: the response strobe lasts one clock
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R10: the error flag holds until a start clears it
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !strb.clrErr) |=> protoErr);

endmodule

// File: rtl/slotBusMaster.sv
module slotBusMaster
  import slotbus_pkg::*;
#(
  parameter int HIGH_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdData,
  input  logic       cmdNack,
  output logic       cmdReady,
  output logic       sclDriveHi,
  output logic       sclDriveLo,
  output logic       sclKeep,
  output logic       sdaDriveHi,
  output logic       sdaDriveLo,
  output logic       sdaKeep,
  input  logic       sdaIn,
  output logic       sdaSample,
  output logic       rspValid,
  output logic [7:0] rspData,
  output logic       rspNack,
  output logic       protoErr
);

  dpStrobe_t strb;

  slotbus_ctrl #(.HIGH_TICKS(HIGH_TICKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .subTick  (subTick),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdReady (cmdReady),
    .strb     (strb)
  );

  slotbus_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdData    (cmdData),
    .cmdNack    (cmdNack),
    .sdaIn      (sdaIn),
    .sclDriveHi (sclDriveHi),
    .sclDriveLo (sclDriveLo),
    .sclKeep    (sclKeep),
    .sdaDriveHi (sdaDriveHi),
    .sdaDriveLo (sdaDriveLo),
    .sdaKeep    (sdaKeep),
    .sdaSample  (sdaSample),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspNack    (rspNack),
    .protoErr   (protoErr)
  );

endmodule

// File: tb/slotBusMaster_bench.sv
module slotBusMaster_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HT         = 3;
  localparam int TICK_DIV   = 3;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       subTick = 1'b0;
  logic       cmdValid;
  logic [2:0] cmdOp;
  logic [7:0] cmdData;
  logic       cmdNack;
  logic       cmdReady;
  logic       sclDriveHi, sclDriveLo, sclKeep;
  logic       sdaDriveHi, sdaDriveLo, sdaKeep;
  logic       sdaIn = 1'b1;
  logic       sdaSample;
  logic       rspValid;
  logic [7:0] rspData;
  logic       rspNack;
  logic       protoErr;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slotBusMaster #(.HIGH_TICKS(HT)) u_slotBusMaster (
    .clk(clk), .rstN(rstN), .subTick(subTick),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData), .cmdNack(cmdNack),
    .cmdReady(cmdReady),
    .sclDriveHi(sclDriveHi), .sclDriveLo(sclDriveLo), .sclKeep(sclKeep),
    .sdaDriveHi(sdaDriveHi), .sdaDriveLo(sdaDriveLo), .sdaKeep(sdaKeep),
    .sdaIn(sdaIn), .sdaSample(sdaSample),
    .rspValid(rspValid), .rspData(rspData), .rspNack(rspNack), .protoErr(protoErr)
  );

  // slot tick from a free-running divider
  int divCnt = 0;
  always @(negedge clk) begin
    divCnt  = (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    subTick = (divCnt == TICK_DIV - 1);
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // code = {sclHi, sclLo, sdaHi, sdaLo}
  typedef struct packed {
    logic [3:0] code;
    logic       slv;
    logic       sv;
    logic       s;
    logic       last;
    logic [3:0] req;
  } ent_t;

  ent_t q[$];
  ent_t cur = '0;
  bit   curValid = 0, pending = 0, active = 0;
  bit   expReady = 1, expRspValid = 0, expErr = 0, expSample = 1;
  logic [7:0] expData = 0, pendData = 0;
  bit   expNack = 0, pendNack = 0;
  int   curOp = 0;
  logic [7:0] slvByte = 8'h00;
  bit   slvAck = 1;

  function automatic ent_t mk(logic [3:0] code, bit slv, bit sv, bit s, logic [3:0] req);
    ent_t e;
    e.code = code; e.slv = slv; e.sv = sv; e.s = s; e.last = 1'b0; e.req = req;
    return e;
  endfunction

  function automatic void pushLow(bit mLo, bit slvLo, bit smp, logic [3:0] req);
    q.push_back(mk(4'b0100, 0, 0, 0, req));
    q.push_back(mk(4'b0110, 0, 0, 0, req));
    q.push_back(mk(4'b0100, 0, 0, 0, req));
    q.push_back(mk({3'b010, mLo}, slvLo, 0, 0, req));
    q.push_back(mk(4'b0100, 0, 1, smp, req));
  endfunction

  function automatic void pushHigh(logic [3:0] req);
    for (int i = 0; i < HT; i++) q.push_back(mk(i == 0 ? 4'b1000 : 4'b0000, 0, 0, 0, req));
  endfunction

  function automatic void pushEdge(bit toHigh, logic [3:0] req);
    q.push_back(mk(4'b1000, 0, 0, 0, req));
    q.push_back(mk(4'b0000, 0, 0, 0, req));
    q.push_back(mk({2'b00, toHigh, !toHigh}, 0, 0, 0, req));
    q.push_back(mk(4'b0000, 0, 0, 0, req));
  endfunction

  function automatic void build(int op, logic [7:0] d, bit n);
    case (op)
      1: begin // R11
        if (active) pushLow(0, 0, 1, 4'd11);
        pushEdge(0, 4'd11);
        active = 1;
      end
      4: begin // R12
        pushLow(1, 0, 0, 4'd12);
        pushEdge(1, 4'd12);
        active = 0;
      end
      2: begin
        for (int i = 7; i >= 0; i--) begin pushLow(!d[i], 0, d[i], 4'd8); pushHigh(4'd8); end
        pushLow(0, slvAck, !slvAck, 4'd8); pushHigh(4'd8);
        pendData = d; pendNack = !slvAck;
      end
      default: begin
        for (int i = 7; i >= 0; i--) begin pushLow(0, !slvByte[i], slvByte[i], 4'd9); pushHigh(4'd9); end
        pushLow(!n, 0, n, 4'd9); pushHigh(4'd9);
        pendData = slvByte; pendNack = n;
      end
    endcase
    q[q.size()-1].last = 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); curValid = 0; pending = 0; active = 0;
      expReady = 1; expRspValid = 0; expErr = 0; expSample = 1;
    end else begin
      expRspValid = 0;
      if (subTick) begin
        if (curValid) begin
          if (cur.sv) expSample = cur.s;
          if (cur.last) begin
            curValid = 0; expReady = 1;
            if (curOp == 2 || curOp == 3) begin
              expRspValid = 1; expData = pendData; expNack = pendNack;
              if (curOp == 2 && pendNack) expErr = 1;
            end
          end else cur = q.pop_front();
        end else if (pending) begin
          cur = q.pop_front(); curValid = 1; pending = 0;
        end
      end
      if (expReady && cmdValid && cmdOp >= 3'd1 && cmdOp <= 3'd4) begin
        build(int'(cmdOp), cmdData, cmdNack);
        if (cmdOp == 3'd1) expErr = 0;
        expReady = 0; pending = 1; curOp = int'(cmdOp);
      end
    end
  end

  // compare every clock, then resolve the bus line
  logic line = 1'b1;
  always @(negedge clk) begin
    ent_t e;
    string t;
    e = curValid ? cur : '0;
    t = (e.req == 0) ? "R4" : $sformatf("R4 (R%0d)", e.req);
    chk("R2 sclDriveLo", sclDriveLo, e.code[2]);
    chk("R3 sdaDriveHi", sdaDriveHi, e.code[1]);
    chk({t, " sdaDriveLo"}, sdaDriveLo, e.code[0]);
    chk("R5 sclDriveHi", sclDriveHi, e.code[3]);
    chk("R6 sclKeep", sclKeep, !(e.code[3] | e.code[2]));
    chk("R6 sdaKeep", sdaKeep, !(e.code[1] | e.code[0]));
    chk("R1 cmdReady", cmdReady, expReady);
    chk("R8 rspValid", rspValid, expRspValid);
    if (expRspValid) begin
      chk(curOp == 3 ? "R9 rspData" : "R8 rspData", rspData, expData);
      chk(curOp == 3 ? "R9 rspNack" : "R8 rspNack", rspNack, expNack);
    end
    chk("R10 protoErr", protoErr, expErr);
    chk("R7 sdaSample", sdaSample, expSample);
    if (sdaDriveLo || e.slv) line = 1'b0;
    else if (sdaDriveHi)     line = 1'b1;
    sdaIn = line;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic n);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdNack = n;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
    if (op >= 3'd1 && op <= 3'd4) while (!cmdReady) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 3'd0; cmdData = 8'h00; cmdNack = 1'b0;
    idle(4);
    // R13: values held under reset
    chk("R13 cmdReady", cmdReady, 1);
    chk("R13 drives", {sclDriveHi, sclDriveLo, sdaDriveHi, sdaDriveLo}, 0);
    chk("R13 keepers", {sclKeep, sdaKeep}, 2'b11);
    chk("R13 rspValid", rspValid, 0);
    chk("R13 protoErr", protoErr, 0);
    chk("R13 sdaSample", sdaSample, 1);
    rstN = 1'b1;

    issue(3'd5, 8'h00, 0);           // R1: unknown code ignored
    idle(20);
    issue(3'd1, 8'h00, 0);           // R11 start from idle
    slvAck = 1; issue(3'd2, 8'hA5, 0); // R8 write acked
    slvAck = 0; issue(3'd2, 8'h3C, 0); // R10 write not acked
    idle(2);
    chk("R10 set after nack", protoErr, 1);
    slvByte = 8'h96; issue(3'd3, 8'h00, 0); // R9 read answered ack
    chk("R10 still held", protoErr, 1);
    issue(3'd1, 8'h00, 0);           // R11 repeated start clears the flag
    chk("R10 cleared by start", protoErr, 0);
    slvAck = 1; issue(3'd2, 8'h00, 0);
    slvByte = 8'h5A; issue(3'd3, 8'h00, 1); // R9 read answered nack
    issue(3'd4, 8'h00, 0);           // R12 stop
    issue(3'd1, 8'h00, 0);
    slvAck = 1; issue(3'd2, 8'hFF, 0);
    issue(3'd4, 8'h00, 0);
    issue(3'd7, 8'h12, 0);           // R1: unknown code ignored
    issue(3'd0, 8'h34, 0);
    idle(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule